// File: doc/BRIEF.md
# Bit-Test and Clear Executor

This block is the execute stage for a small group of 14-bit instruction words: test a bit of a file register and skip if it is set, clear a file register, clear the working register, and recognise a subroutine call. Each cycle it decodes the word on `instr` and reads one entry of a 128 by 8-bit register file through the 7-bit file-address field. It then either raises a request to the sequencer or updates the register file, the working register and the zero flag.

Skip and call requests are combinational outputs, valid during the execute cycle itself. Register-file, working-register and zero-flag updates take effect on the clock edge that ends the execute cycle. Other execution units write their results back through dedicated ports for file registers, the working register and the zero flag. When a clear and a writeback hit the same target in the same cycle, the clear wins. When the sequencer flushes the slot, the executor leaves all state unchanged and raises no request.

Top module: `bitop_exec`

## Requirements
- R1: While `rst_n` is low at a clock edge, every file register, the working register and the zero flag are cleared to 0; after reset `skip_req` and `call_req` are low for a NOP word (0x0000).
- R2: A bit-test word `01_11bb_bfff_ffff` (bits 13:10 = 0111, bit index in bits 9:7, file address in bits 6:0) drives `skip_req` high in the same cycle exactly when bit b of register f is 1. All eight bit positions can be tested.
- R3: A bit-test word changes neither the zero flag, the working register nor any file register.
- R4: A clear-register word `00_0001_1fff_ffff` (bits 13:7 = 0000011) writes 0x00 to register f and sets the zero flag to 1 at the end of the cycle; no other file register changes.
- R5: The clear-working-register word, exactly 0x0083, writes 0x00 to the working register and sets the zero flag to 1 at the end of the cycle.
- R6: A call word `10_0kkk_kkkk_kkkk` (bits 13:11 = 100) drives `call_req` high in the same cycle, with `call_target` equal to the 11-bit field k in bits 10:0, and changes no state.
- R7: Any other word behaves as a NOP: no skip, no call, and no change to file registers, working register or zero flag.
- R8: With `slot_flush` high, the word has no effect at all: no request, and no change to file registers, working register or zero flag.
- R9: In a cycle where a clear and a writeback target the same register, working register or zero flag, the clear's value (0x00, or Z = 1) is the one stored.
- R10: The writeback ports store `wb_reg_data` into register `wb_reg_addr`, `wb_w_data` into the working register, and `wb_z_data` into the zero flag at the end of the cycle in which their enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_flush | input | 1 | Sequencer marks the current slot as discarded |
| instr | input | 14 | Instruction word in execute |
| wb_reg_en | input | 1 | Writeback enable for a file register |
| wb_reg_addr | input | 7 | Writeback file address |
| wb_reg_data | input | 8 | Writeback file data |
| wb_w_en | input | 1 | Writeback enable for the working register |
| wb_w_data | input | 8 | Writeback working-register data |
| wb_z_en | input | 1 | Writeback enable for the zero flag |
| wb_z_data | input | 1 | Writeback zero-flag value |
| w_out | output | 8 | Working register |
| z_out | output | 1 | Zero flag |
| skip_req | output | 1 | Request to discard the next fetched word |
| call_req | output | 1 | Call recognised in this cycle |
| call_target | output | 11 | Call target address field |

## Verification
Embedded properties check the following on every cycle: a flushed slot raises no request, an executed clear leaves the zero flag set and the cleared target at zero, a bit-test with no flag writeback leaves the zero flag stable, and a call request carries the word's target field. The bench scenarios are what show that decoding is exact: every bit of every register is tested against a known preload, and all 16384 words are swept to show that unrecognised words leave all state untouched. The scenarios also cover clear-versus-writeback priority and the exact values stored after flushes.

// File: rtl/bitop_pkg.sv
// Package: shared widths, operation codes and encoding constants for the
// bit-test/clear executor. Assumes a 14-bit word with a 7-bit file field.
package bitop_pkg;
    localparam int INSN_W   = 14;
    localparam int ADDR_W   = 7;
    localparam int DATA_W   = 8;
    localparam int BIDX_W   = 3;
    localparam int TGT_W    = 11;

    // Decoded operation class
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_BTEST = 3'd1,
        OP_CLRF  = 3'd2,
        OP_CLRW  = 3'd3,
        OP_CALL  = 3'd4
    } op_e;

    localparam logic [3:0]        BTEST_PFX = 4'b0111;
    localparam logic [6:0]        CLRF_PFX  = 7'b0000011;
    localparam logic [INSN_W-1:0] CLRW_WORD = 14'h0083;
    localparam logic [2:0]        CALL_PFX  = 3'b100;
endpackage

// File: rtl/bitop_decode.sv
// Module: bitop_decode
// Classifies a 14-bit word into one of the supported operations and splits
// out its fields. Purely combinational; words outside the set yield OP_NOP.
module bitop_decode
    import bitop_pkg::*;
#(
    parameter int IW = INSN_W,
    parameter int AW = ADDR_W,
    parameter int BW = BIDX_W,
    parameter int TW = TGT_W
) (
    input  logic [IW-1:0] instr,
    output op_e           op,
    output logic [AW-1:0] f_addr,
    output logic [BW-1:0] bit_idx,
    output logic [TW-1:0] target
);
    localparam int BLO = AW;
    localparam int BHI = AW + BW - 1;

    // Field extraction is position-fixed by the encoding
    always_comb begin
        f_addr  = instr[AW-1:0];
        bit_idx = instr[BHI:BLO];
        target  = instr[TW-1:0];
    end

    // Priority-free classification: the prefixes do not overlap
    always_comb begin
        if (instr[IW-1:IW-4] == BTEST_PFX)
            op = OP_BTEST;
        else if (instr[IW-1:IW-7] == CLRF_PFX)
            op = OP_CLRF;
        else if (instr == CLRW_WORD)
            op = OP_CLRW;
        else if (instr[IW-1:IW-3] == CALL_PFX)
            op = OP_CALL;
        else
            op = OP_NOP;
    end
endmodule

// File: rtl/bitop_regfile.sv
// Module: bitop_regfile
// 2^AW by DW register file with asynchronous read, a clear port and a
// writeback port. The clear port wins over writeback on the same entry.
// Assumes synchronous active-low reset clears every entry.
module bitop_regfile #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          clr_en,
    input  logic [AW-1:0] clr_addr,
    input  logic          ext_en,
    input  logic [AW-1:0] ext_addr,
    input  logic [DW-1:0] ext_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // One update process per entry, clear before writeback
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[gi] <= '0;
            else if (clr_en && clr_addr == AW'(gi))
                mem[gi] <= '0;
            else if (ext_en && ext_addr == AW'(gi))
                mem[gi] <= ext_data;
        end
    end

    // Asynchronous read of the addressed entry
    always_comb rd_data = mem[rd_addr];

    // R4 / R9: a cleared entry holds zero after the edge
    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> (mem[$past(clr_addr)] == '0));
endmodule

// File: rtl/bitop_wz.sv
// Module: bitop_wz
// Working register and zero flag. Clear operations force W to zero and the
// flag to one, taking priority over writeback from other units.
module bitop_wz #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_w,
    input  logic          set_z,
    input  logic          w_wr,
    input  logic [DW-1:0] w_wdata,
    input  logic          z_wr,
    input  logic          z_wdata,
    output logic [DW-1:0] w_q,
    output logic          z_q
);
    // Working register update, clear beats writeback
    always_ff @(posedge clk) begin
        if (!rst_n)
            w_q <= '0;
        else if (clr_w)
            w_q <= '0;
        else if (w_wr)
            w_q <= w_wdata;
    end

    // Zero flag update, a clear operation beats writeback
    always_ff @(posedge clk) begin
        if (!rst_n)
            z_q <= 1'b0;
        else if (set_z)
            z_q <= 1'b1;
        else if (z_wr)
            z_q <= z_wdata;
    end

    // R5: working register is zero after a clear-W
    assert_clrw_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> (w_q == '0));

    // R10: without a clear, a W writeback lands
    assert_w_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (w_wr && !clr_w) |=> (w_q == $past(w_wdata)));
endmodule

// File: rtl/bitop_exec.sv
// Module: bitop_exec (top)
// Execute stage for bit-test-skip, clear-register, clear-W and call words.
// Requests are combinational in the execute cycle; state updates on the
// edge ending it. A flushed slot has no effect. Assumes the sequencer
// holds instr stable for the whole cycle.
module bitop_exec
    import bitop_pkg::*;
#(
    parameter int IW = INSN_W,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int BW = BIDX_W,
    parameter int TW = TGT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_flush,
    input  logic [IW-1:0] instr,
    input  logic          wb_reg_en,
    input  logic [AW-1:0] wb_reg_addr,
    input  logic [DW-1:0] wb_reg_data,
    input  logic          wb_w_en,
    input  logic [DW-1:0] wb_w_data,
    input  logic          wb_z_en,
    input  logic          wb_z_data,
    output logic [DW-1:0] w_out,
    output logic          z_out,
    output logic          skip_req,
    output logic          call_req,
    output logic [TW-1:0] call_target
);
    op_e           op;
    logic [AW-1:0] f_addr;
    logic [BW-1:0] bit_idx;
    logic [TW-1:0] tgt;
    logic [DW-1:0] f_data;
    logic          live;
    logic          do_clrf;
    logic          do_clrw;

    bitop_decode #(.IW(IW), .AW(AW), .BW(BW), .TW(TW)) u_dec (
        .instr   (instr),
        .op      (op),
        .f_addr  (f_addr),
        .bit_idx (bit_idx),
        .target  (tgt)
    );

    bitop_regfile #(.AW(AW), .DW(DW)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (f_addr),
        .rd_data  (f_data),
        .clr_en   (do_clrf),
        .clr_addr (f_addr),
        .ext_en   (wb_reg_en),
        .ext_addr (wb_reg_addr),
        .ext_data (wb_reg_data)
    );

    bitop_wz #(.DW(DW)) u_wz (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_w   (do_clrw),
        .set_z   (do_clrf || do_clrw),
        .w_wr    (wb_w_en),
        .w_wdata (wb_w_data),
        .z_wr    (wb_z_en),
        .z_wdata (wb_z_data),
        .w_q     (w_out),
        .z_q     (z_out)
    );

    // Gate every side effect with the flush qualifier
    always_comb begin
        live    = !slot_flush;
        do_clrf = live && (op == OP_CLRF);
        do_clrw = live && (op == OP_CLRW);
    end

    // Sequencer requests for the current execute cycle
    always_comb begin
        skip_req    = live && (op == OP_BTEST) && f_data[bit_idx];
        call_req    = live && (op == OP_CALL);
        call_target = tgt;
    end

    // R8: a flushed slot never raises a request
    assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slot_flush |-> (!skip_req && !call_req));

    // R4 / R5 / R9: any executed clear leaves Z set
    assert_clear_sets_z_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_flush && (instr[IW-1:IW-7] == CLRF_PFX || instr == CLRW_WORD))
        |=> z_out);

    // R3: bit-test without a flag writeback keeps Z
    assert_btest_keeps_z_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[IW-1:IW-4] == BTEST_PFX && !wb_z_en) |=> $stable(z_out));

    // R6: a call request carries the word's target field
    assert_call_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> (call_target == instr[TW-1:0]
                      && instr[IW-1:IW-3] == CALL_PFX));
endmodule

// File: tb/bitop_exec_tb.sv
module bitop_exec_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_flush = 1'b0;
    logic [13:0] instr = 14'h0000;
    logic        wb_reg_en = 1'b0;
    logic [6:0]  wb_reg_addr = '0;
    logic [7:0]  wb_reg_data = '0;
    logic        wb_w_en = 1'b0;
    logic [7:0]  wb_w_data = '0;
    logic        wb_z_en = 1'b0;
    logic        wb_z_data = 1'b0;
    logic [7:0]  w_out;
    logic        z_out;
    logic        skip_req;
    logic        call_req;
    logic [10:0] call_target;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_mem [128];
    logic       sk, cl;
    logic [10:0] tg;
    logic [7:0] wv;
    logic       zv;

    bitop_exec u_dut (
        .clk(clk), .rst_n(rst_n), .slot_flush(slot_flush), .instr(instr),
        .wb_reg_en(wb_reg_en), .wb_reg_addr(wb_reg_addr), .wb_reg_data(wb_reg_data),
        .wb_w_en(wb_w_en), .wb_w_data(wb_w_data), .wb_z_en(wb_z_en),
        .wb_z_data(wb_z_data), .w_out(w_out), .z_out(z_out),
        .skip_req(skip_req), .call_req(call_req), .call_target(call_target)
    );

    always #10 clk = ~clk;

    function automatic logic [13:0] w_btest(input int a, input int b);
        return {4'b0111, 3'(b), 7'(a)};
    endfunction
    function automatic logic [13:0] w_clrf(input int a);
        return {7'b0000011, 7'(a)};
    endfunction
    function automatic logic [13:0] w_call(input int k);
        return {3'b100, 11'(k)};
    endfunction
    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One execute cycle: drive at negedge, sample outputs 2 ns later
    task automatic cyc(input logic [13:0] ins, input logic fl = 1'b0,
                       input logic re = 1'b0, input int ra = 0, input int rd = 0,
                       input logic we = 1'b0, input int wd = 0,
                       input logic ze = 1'b0, input logic zd = 1'b0);
        @(negedge clk);
        instr = ins; slot_flush = fl;
        wb_reg_en = re; wb_reg_addr = 7'(ra); wb_reg_data = 8'(rd);
        wb_w_en = we; wb_w_data = 8'(wd); wb_z_en = ze; wb_z_data = zd;
        #2;
        sk = skip_req; cl = call_req; tg = call_target; wv = w_out; zv = z_out;
    endtask

    // Compare every bit of every register with the bench model
    task automatic sweep_regs(input string req);
        for (int a = 0; a < 128; a++)
            for (int b = 0; b < 8; b++) begin
                cyc(w_btest(a, b));
                chk(req, sk, int'(exp_mem[a][b]));
            end
    endtask

    initial begin
        int cyc_cnt = 0;
        forever begin
            @(posedge clk);
            cyc_cnt++;
            if (cyc_cnt > 150000) begin
                n_fail++; n_chk++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc_cnt);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        cyc(14'h0000, 1'b0, 1'b0, 0, 0, 1'b1, 8'h5A, 1'b1, 1'b1);
        cyc(14'h0000);
        cyc(14'h0000);
        @(negedge clk); rst_n = 1'b1;
        cyc(14'h0000);
        chk("R1 w", wv, 0);
        chk("R1 z", zv, 0);
        chk("R1 skip", sk, 0);
        chk("R1 call", cl, 0);
        for (int a = 0; a < 128; a++) exp_mem[a] = 8'h00;
        for (int a = 0; a < 128; a += 17) begin
            cyc(w_btest(a, a % 8));
            chk("R1 reg", sk, 0);
        end

        // R10: preload all registers, W and Z through writeback
        for (int a = 0; a < 128; a++) begin
            cyc(14'h0000, 1'b0, 1'b1, a, pat(a));
            exp_mem[a] = pat(a);
        end
        cyc(14'h0000, 1'b0, 1'b0, 0, 0, 1'b1, 8'hA5, 1'b1, 1'b0);
        cyc(14'h0000);
        chk("R10 w", wv, 8'hA5);
        chk("R10 z", zv, 0);

        // R2: every bit of every register
        sweep_regs("R2");
        cyc(14'h0000);
        chk("R3 w", wv, 8'hA5);
        chk("R3 z", zv, 0);
        // R3 with Z=1 held across bit tests
        cyc(14'h0000, 1'b0, 1'b0, 0, 0, 1'b0, 0, 1'b1, 1'b1);
        for (int b = 0; b < 8; b++) cyc(w_btest(3, b));
        cyc(14'h0000);
        chk("R3 z held 1", zv, 1);
        chk("R3 w held", wv, 8'hA5);

        // R6: every call target
        for (int k = 0; k < 2048; k++) begin
            cyc(w_call(k));
            chk("R6 call", cl, 1);
            chk("R6 target", tg, k);
            chk("R6 skip", sk, 0);
        end
        cyc(14'h0000);
        chk("R6 w", wv, 8'hA5);
        chk("R6 z", zv, 1);

        // R5: clear W
        cyc(14'h0000, 1'b0, 1'b0, 0, 0, 1'b0, 0, 1'b1, 1'b0);
        cyc(14'h0083);
        chk("R5 skip", sk, 0);
        cyc(14'h0000);
        chk("R5 w", wv, 0);
        chk("R5 z", zv, 1);

        // R4: clear registers at edges and in the middle
        foreach (exp_mem[a]) begin end
        for (int i = 0; i < 3; i++) begin
            int a = (i == 0) ? 0 : (i == 1) ? 10 : 127;
            cyc(14'h0000, 1'b0, 1'b0, 0, 0, 1'b0, 0, 1'b1, 1'b0);
            cyc(w_clrf(a));
            exp_mem[a] = 8'h00;
            cyc(14'h0000);
            chk("R4 z", zv, 1);
        end
        sweep_regs("R4");

        // R8: flushed slots have no effect
        cyc(14'h0000, 1'b0, 1'b0, 0, 0, 1'b1, 8'hA5, 1'b1, 1'b0);
        cyc(w_clrf(20), 1'b1);
        chk("R8 skip", sk, 0);
        cyc(14'h0083, 1'b1);
        cyc(w_call(5), 1'b1);
        chk("R8 call", cl, 0);
        for (int b = 0; b < 8; b++) begin
            cyc(w_btest(20, b), 1'b1);
            chk("R8 btest", sk, 0);
        end
        cyc(14'h0000);
        chk("R8 w", wv, 8'hA5);
        chk("R8 z", zv, 0);
        for (int b = 0; b < 8; b++) begin
            cyc(w_btest(20, b));
            chk("R8 reg", sk, int'(exp_mem[20][b]));
        end

        // R7: every word outside the set is a NOP
        for (int x = 0; x < 16384; x++) begin
            logic [13:0] ins = 14'(x);
            if (ins[13:10] == 4'b0111 || ins[13:7] == 7'b0000011 ||
                ins == 14'h0083 || ins[13:11] == 3'b100) continue;
            cyc(ins);
            chk("R7 skip", sk, 0);
            chk("R7 call", cl, 0);
            if (wv != 8'hA5 || zv != 1'b0) chk("R7 wz", {wv, 7'b0, zv}, 16'hA500);
        end
        cyc(14'h0000);
        chk("R7 w", wv, 8'hA5);
        chk("R7 z", zv, 0);
        sweep_regs("R7");

        // R9: clear beats writeback on the same target
        cyc(w_clrf(30), 1'b0, 1'b1, 30, 8'hFF, 1'b0, 0, 1'b1, 1'b0);
        exp_mem[30] = 8'h00;
        cyc(14'h0083, 1'b0, 1'b0, 0, 0, 1'b1, 8'hFF, 1'b1, 1'b0);
        chk("R9 clrf z", zv, 1);
        cyc(14'h0000);
        chk("R9 w", wv, 0);
        chk("R9 z", zv, 1);
        for (int b = 0; b < 8; b++) begin
            cyc(w_btest(30, b));
            chk("R9 reg", sk, 0);
        end

        // R10: writeback of a fresh value, then tested bit by bit
        cyc(14'h0000, 1'b0, 1'b1, 40, 8'h81);
        exp_mem[40] = 8'h81;
        for (int b = 0; b < 8; b++) begin
            cyc(w_btest(40, b));
            chk("R10 reg", sk, int'(exp_mem[40][b]));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule